// File: doc/BRIEF.md
# Seven-Slot Pixel Serializer

This block turns a parallel pixel stream into serial bit streams for a flat-panel link. A pixel is 8-bit red, green and blue plus horizontal sync, vertical sync and data enable. The block spreads each pixel over seven bit slots on four data lanes. A fifth, clock-like lane repeats a fixed seven-slot pattern, so the receiver can find the pixel boundaries. The whole block runs on a bit clock at seven times the pixel rate. Differential pads, the fast clock source and double-rate output cells sit outside the block.

A mode input chooses one of three colour-to-slot layouts: one 18-bit layout and two 24-bit layouts. A mirror input sends every data lane in reverse slot order. The block samples the pixel, the mode and the mirror setting together, and only at the bit-clock edge that ends slot 6. It raises `px_take` during slot 6 to tell the pixel source that this edge is coming. A sampled pixel waits for one pixel period in a staging register. It is then loaded into the lane shifters and sent during the following pixel period, with the mode and mirror setting that were sampled with it.

Top module: `px7_serializer`

## Requirements
- R1: A 3-bit slot counter steps 0,1,...,6,0 on every bit-clock edge. `px_take` is 1 exactly while the slot is 6. The pixel, `cfg_map` and `cfg_mirror` are sampled only on the edge that ends slot 6.
- R2: When `cfg_map` is 0, and also when it is 3, the 18-bit layout is used. Serial slots 0..6 carry: on lane 0, g[2], r[7], r[6], r[5], r[4], r[3], r[2]; on lane 1, b[3], b[2], g[7], g[6], g[5], g[4], g[3]; on lane 2, de, vs, hs, b[7], b[6], b[5], b[4]. Lane 3 stays 0. Bits [1:0] of each colour have no effect.
- R3: When `cfg_map` is 1, lanes 0 to 2 are the same as in R2. Lane 3 carries 0, b[1], b[0], g[1], g[0], r[1], r[0] in slots 0..6.
- R4: When `cfg_map` is 2, the slots carry, for slots 0..6: on lane 0, g[0], r[5], r[4], r[3], r[2], r[1], r[0]; on lane 1, b[1], b[0], g[5], g[4], g[3], g[2], g[1]; on lane 2, de, vs, hs, b[5], b[4], b[3], b[2]; on lane 3, 0, b[7], b[6], g[7], g[6], r[7], r[6].
- R5: In every layout, slots 0, 1 and 2 of lane 2 carry data enable, vertical sync and horizontal sync, in that order. Slot 0 of lane 3 is always 0.
- R6: When the sampled `cfg_mirror` is 1, every data lane sends its seven slots in reverse order: slot 6 first and slot 0 last.
- R7: In slots 0..6, `clk_out` is 1,1,0,0,0,1,1. It follows the slot counter in every pixel period, including the period that starts at reset.
- R8: A pixel sampled on the edge that ends slot 6 of period k is sent during period k+2, with the `cfg_map` and `cfg_mirror` values sampled on the same edge. Changes to any input at other edges have no effect on the lanes.
- R9: A synchronous active-high `rst` sets the slot to 0, drives every data lane to 0 and clears the staging register. As a result, the first two pixel periods after reset carry all zeros on the data lanes. During reset `clk_out` is 1 and `px_take` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven edges per pixel |
| rst | input | 1 | Synchronous reset, active high |
| px_red | input | 8 | Red component |
| px_grn | input | 8 | Green component |
| px_blu | input | 8 | Blue component |
| px_hs | input | 1 | Horizontal sync |
| px_vs | input | 1 | Vertical sync |
| px_de | input | 1 | Data enable |
| cfg_map | input | 2 | Layout select (0/3: 18-bit, 1 and 2: the two 24-bit layouts) |
| cfg_mirror | input | 1 | Reverse slot order on the data lanes |
| px_take | output | 1 | High during slot 6; inputs are sampled at the end of it |
| lane_out | output | 4 | Serial data lanes 0..3 |
| clk_out | output | 1 | Pixel-framing clock lane |

## Verification
All outputs are registers. `clk_out` and `px_take` are due in the same cycle that the slot counter reaches a given slot. A lane bit is due two pixel boundaries after its pixel is sampled, in the slot named by the layout. The bench model keeps its own slot count, advanced on each rising edge. On the wrap edge the model moves its staged pixel to the "now sending" set and stages the current inputs. It samples the DUT outputs on the falling edge, so each comparison lands in the slot where that value is due. The bench collects the seven slots of each lane into a word and checks the word at slot 6. In one phase the bench changes every input, mode and mirror included, on every cycle. The model still samples only on the wrap edge, so any leak from a mid-pixel change shows up as a mismatch in the collected words.

// File: rtl/px7_pkg.sv
package px7_pkg;

  localparam int SLOTS  = 7;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int LANES  = 4;
  localparam int CH_W   = 8;

  typedef enum logic [1:0] {
    MAP_NARROW = 2'd0,
    MAP_SPLIT  = 2'd1,
    MAP_TOP    = 2'd2,
    MAP_ALT    = 2'd3
  } map_e;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
    logic            hs;
    logic            vs;
    logic            de;
  } pixel_t;

  typedef logic [SLOTS-1:0] word_t;

  // bit i of the result is serial slot i
  function automatic word_t slots7(input logic s0, input logic s1, input logic s2,
                                   input logic s3, input logic s4, input logic s5,
                                   input logic s6);
    return {s6, s5, s4, s3, s2, s1, s0};
  endfunction

endpackage

// File: rtl/px7_slot_timer.sv
module px7_slot_timer
  import px7_pkg::*;
#(
  parameter int          NSLOT   = SLOTS,
  parameter logic [NSLOT-1:0] CLK_PAT = 7'b1100011,
  localparam int         SW      = $clog2(NSLOT)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [SW-1:0] slot,
  output logic          last,
  output logic          take,
  output logic          clk_lane
);

  localparam logic [SW-1:0] LAST_SLOT = SW'(NSLOT - 1);
  localparam logic [SW-1:0] PRE_LAST  = SW'(NSLOT - 2);

  logic [NSLOT-1:0] pat_q;

  assign last     = (slot == LAST_SLOT);
  assign clk_lane = pat_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      slot  <= '0;
      take  <= 1'b0;
      pat_q <= CLK_PAT;
    end else begin
      slot  <= last ? '0 : slot + SW'(1);
      take  <= (slot == PRE_LAST);
      pat_q <= {pat_q[0], pat_q[NSLOT-1:1]};
    end
  end

endmodule

// File: rtl/px7_lane_mapper.sv
module px7_lane_mapper
  import px7_pkg::*;
(
  input  pixel_t                       px,
  input  map_e                         mode,
  output logic [LANES-1:0][SLOTS-1:0]  words
);

  word_t base0, base1, base2, ext3;
  word_t top0, top1, top2, top3;

  // MSB-aligned layout shared by the 18-bit and split 24-bit modes
  assign base0 = slots7(px.g[2], px.r[7], px.r[6], px.r[5], px.r[4], px.r[3], px.r[2]);
  assign base1 = slots7(px.b[3], px.b[2], px.g[7], px.g[6], px.g[5], px.g[4], px.g[3]);
  assign base2 = slots7(px.de,   px.vs,   px.hs,   px.b[7], px.b[6], px.b[5], px.b[4]);
  assign ext3  = slots7(1'b0,    px.b[1], px.b[0], px.g[1], px.g[0], px.r[1], px.r[0]);

  // LSB-aligned layout with the top two bits on lane 3
  assign top0 = slots7(px.g[0], px.r[5], px.r[4], px.r[3], px.r[2], px.r[1], px.r[0]);
  assign top1 = slots7(px.b[1], px.b[0], px.g[5], px.g[4], px.g[3], px.g[2], px.g[1]);
  assign top2 = slots7(px.de,   px.vs,   px.hs,   px.b[5], px.b[4], px.b[3], px.b[2]);
  assign top3 = slots7(1'b0,    px.b[7], px.b[6], px.g[7], px.g[6], px.r[7], px.r[6]);

  always_comb begin
    unique case (mode)
      MAP_SPLIT: words = {ext3, base2, base1, base0};
      MAP_TOP:   words = {top3, top2, top1, top0};
      default:   words = {word_t'(0), base2, base1, base0};
    endcase
  end

endmodule

// File: rtl/px7_lane_shift.sv
module px7_lane_shift #(
  parameter int NSLOT = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             mirror,
  input  logic [NSLOT-1:0] word,
  output logic             q
);

  logic [NSLOT-1:0] rev;
  logic [NSLOT-1:0] sh_q;

  for (genvar i = 0; i < NSLOT; i++) begin : g_rev
    assign rev[i] = word[NSLOT-1-i];
  end

  assign q = sh_q[0];

  always_ff @(posedge clk) begin
    if (rst)       sh_q <= '0;
    else if (load) sh_q <= mirror ? rev : word;
    else           sh_q <= {1'b0, sh_q[NSLOT-1:1]};
  end

endmodule

// File: rtl/px7_serializer.sv
module px7_serializer
  import px7_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [CH_W-1:0]     px_red,
  input  logic [CH_W-1:0]     px_grn,
  input  logic [CH_W-1:0]     px_blu,
  input  logic                px_hs,
  input  logic                px_vs,
  input  logic                px_de,
  input  logic [1:0]          cfg_map,
  input  logic                cfg_mirror,
  output logic                px_take,
  output logic [LANES-1:0]    lane_out,
  output logic                clk_out
);

  logic [SLOT_W-1:0]            slot;
  logic                         wrap;
  pixel_t                       pix_q;
  map_e                         map_q;
  logic                         mir_q;
  map_e                         act_map;
  logic                         act_mirror;
  logic [LANES-1:0][SLOTS-1:0]  words;

  px7_slot_timer #(.NSLOT(SLOTS)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .slot     (slot),
    .last     (wrap),
    .take     (px_take),
    .clk_lane (clk_out)
  );

  // staging register: pixel and its configuration travel together
  always_ff @(posedge clk) begin
    if (rst) begin
      pix_q      <= '0;
      map_q      <= MAP_NARROW;
      mir_q      <= 1'b0;
      act_map    <= MAP_NARROW;
      act_mirror <= 1'b0;
    end else if (wrap) begin
      pix_q      <= '{r: px_red, g: px_grn, b: px_blu, hs: px_hs, vs: px_vs, de: px_de};
      map_q      <= map_e'(cfg_map);
      mir_q      <= cfg_mirror;
      act_map    <= map_q;
      act_mirror <= mir_q;
    end
  end

  px7_lane_mapper u_mapper (
    .px    (pix_q),
    .mode  (map_q),
    .words (words)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    px7_lane_shift #(.NSLOT(SLOTS)) u_shift (
      .clk    (clk),
      .rst    (rst),
      .load   (wrap),
      .mirror (mir_q),
      .word   (words[l]),
      .q      (lane_out[l])
    );
  end

endmodule

// File: rtl/px7_serializer_chk.sv
module px7_serializer_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] slot,
  input logic [1:0] act_map,
  input logic       act_mirror,
  input logic       px_take,
  input logic [3:0] lane_out,
  input logic       clk_out
);

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
    slot <= 3'd6); // R1

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
    (slot != 3'd6) |=> (slot == $past(slot) + 3'd1)); // R1

  AST_TAKE_SLOT6: assert property (@(posedge clk) disable iff (rst)
    px_take == (slot == 3'd6)); // R1

  AST_LANE3_NARROW: assert property (@(posedge clk) disable iff (rst)
    ((act_map == 2'd0) || (act_map == 2'd3)) |-> !lane_out[3]); // R2

  AST_CTL3_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((slot == 3'd0 && !act_mirror) || (slot == 3'd6 && act_mirror)) |-> !lane_out[3]); // R5

  AST_CLK_LANE: assert property (@(posedge clk) disable iff (rst)
    clk_out == (slot == 3'd0 || slot == 3'd1 || slot == 3'd5 || slot == 3'd6)); // R7

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (slot != 3'd6) |=> ($stable(act_map) && $stable(act_mirror))); // R8

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (lane_out == 4'd0)); // R9

endmodule

bind px7_serializer px7_serializer_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .slot       (slot),
  .act_map    (act_map),
  .act_mirror (act_mirror),
  .px_take    (px_take),
  .lane_out   (lane_out),
  .clk_out    (clk_out)
);

// File: tb/test_px7_serializer.sv
module test_px7_serializer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] px_red = '0, px_grn = '0, px_blu = '0;
  logic       px_hs = 1'b0, px_vs = 1'b0, px_de = 1'b0;
  logic [1:0] cfg_map = '0;
  logic       cfg_mirror = 1'b0;
  logic       px_take;
  logic [3:0] lane_out;
  logic       clk_out;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit chaos    = 1'b0;

  px7_serializer i_px7_serializer (
    .clk(clk), .rst(rst),
    .px_red(px_red), .px_grn(px_grn), .px_blu(px_blu),
    .px_hs(px_hs), .px_vs(px_vs), .px_de(px_de),
    .cfg_map(cfg_map), .cfg_mirror(cfg_mirror),
    .px_take(px_take), .lane_out(lane_out), .clk_out(clk_out)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // expected serial word, bit k = slot k, from the layout tables
  function automatic logic [6:0] lane_word(input int mode, input int lane,
      input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
      input logic hs, input logic vs, input logic de);
    logic [6:0] w;
    w = '0;
    if (mode == 2) begin
      case (lane)
        0: begin w[0] = g[0]; for (int k = 1; k < 7; k++) w[k] = r[6-k]; end
        1: begin w[0] = b[1]; w[1] = b[0]; for (int k = 2; k < 7; k++) w[k] = g[7-k]; end
        2: begin w[0] = de; w[1] = vs; w[2] = hs; for (int k = 3; k < 7; k++) w[k] = b[8-k]; end
        default: begin w[1] = b[7]; w[2] = b[6]; w[3] = g[7]; w[4] = g[6]; w[5] = r[7]; w[6] = r[6]; end
      endcase
    end else begin
      case (lane)
        0: begin w[0] = g[2]; for (int k = 1; k < 7; k++) w[k] = r[8-k]; end
        1: begin w[0] = b[3]; w[1] = b[2]; for (int k = 2; k < 7; k++) w[k] = g[9-k]; end
        2: begin w[0] = de; w[1] = vs; w[2] = hs; for (int k = 3; k < 7; k++) w[k] = b[10-k]; end
        default: if (mode == 1) begin
          w[1] = b[1]; w[2] = b[0]; w[3] = g[1]; w[4] = g[0]; w[5] = r[1]; w[6] = r[0];
        end
      endcase
    end
    return w;
  endfunction

  function automatic logic [6:0] flip7(input logic [6:0] w);
    logic [6:0] o;
    for (int k = 0; k < 7; k++) o[k] = w[6-k];
    return o;
  endfunction

  // behavioural reference model
  int         s = 0;
  int         win = 0;
  logic [7:0] h_r = '0, h_g = '0, h_b = '0;
  logic       h_hs = 0, h_vs = 0, h_de = 0, h_mir = 0;
  int         h_map = 0;
  logic [6:0] shown [4];
  logic       sh_hs = 0, sh_vs = 0, sh_de = 0, sh_mir = 0;
  int         sh_map = 0;
  logic [6:0] cap [4];

  initial for (int l = 0; l < 4; l++) begin shown[l] = '0; cap[l] = '0; end

  always @(posedge clk) begin
    if (rst) begin
      s = 0; win = 0;
      h_r = '0; h_g = '0; h_b = '0; h_hs = 0; h_vs = 0; h_de = 0; h_mir = 0; h_map = 0;
      sh_hs = 0; sh_vs = 0; sh_de = 0; sh_mir = 0; sh_map = 0;
      for (int l = 0; l < 4; l++) shown[l] = '0;
    end else if (s == 6) begin
      for (int l = 0; l < 4; l++) begin
        shown[l] = lane_word(h_map, l, h_r, h_g, h_b, h_hs, h_vs, h_de);
        if (h_mir) shown[l] = flip7(shown[l]);
      end
      sh_hs = h_hs; sh_vs = h_vs; sh_de = h_de; sh_mir = h_mir; sh_map = h_map;
      h_r = px_red; h_g = px_grn; h_b = px_blu;
      h_hs = px_hs; h_vs = px_vs; h_de = px_de;
      h_map = int'(cfg_map); h_mir = cfg_mirror;
      s = 0; win++;
    end else begin
      s++;
    end
  end

  // output comparison away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check(px_take == (s == 6), "R1 px_take", int'(px_take), int'(s == 6));
      check(clk_out == ((s <= 1) || (s >= 5)), "R7 clk_out", int'(clk_out),
            int'((s <= 1) || (s >= 5)));
      for (int l = 0; l < 4; l++) cap[l][s] = lane_out[l];
      if (s == 6) begin
        for (int l = 0; l < 4; l++) begin
          string tag;
          if (win < 2)             tag = "R9 zero lanes after reset";
          else if (chaos)          tag = "R8 boundary-only sampling";
          else if (sh_mir)         tag = "R6 mirrored lane";
          else if (sh_map == 1)    tag = "R3 split 24-bit lane";
          else if (sh_map == 2)    tag = "R4 top 24-bit lane";
          else                     tag = "R2 18-bit lane";
          check(cap[l] == shown[l], tag, int'(cap[l]), int'(shown[l]));
        end
        if (win >= 2) begin
          check(cap[2][sh_mir ? 6 : 0] == sh_de, "R5 de slot", int'(cap[2][sh_mir ? 6 : 0]), int'(sh_de));
          check(cap[2][sh_mir ? 5 : 1] == sh_vs, "R5 vs slot", int'(cap[2][sh_mir ? 5 : 1]), int'(sh_vs));
          check(cap[2][sh_mir ? 4 : 2] == sh_hs, "R5 hs slot", int'(cap[2][sh_mir ? 4 : 2]), int'(sh_hs));
          check(cap[3][sh_mir ? 6 : 0] == 1'b0, "R5 lane3 fixed slot", int'(cap[3][sh_mir ? 6 : 0]), 0);
        end
      end
    end
  end

  task automatic rand_pixel();
    px_red = 8'($urandom); px_grn = 8'($urandom); px_blu = 8'($urandom);
    px_hs = 1'($urandom); px_vs = 1'($urandom); px_de = 1'($urandom);
  endtask

  task automatic run_phase(input int map, input bit mir, input int npix, input bit wild);
    cfg_map = 2'(map); cfg_mirror = mir; chaos = wild;
    repeat (npix * 7) begin
      @(negedge clk);
      if (wild) begin
        rand_pixel();
        cfg_map = 2'($urandom); cfg_mirror = 1'($urandom);
      end else if (s == 6) begin
        rand_pixel();
      end
    end
    chaos = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    check(lane_out == 4'd0, "R9 lanes in reset", int'(lane_out), 0);
    check(clk_out == 1'b1, "R9 clk_out in reset", int'(clk_out), 1);
    check(px_take == 1'b0, "R9 px_take in reset", int'(px_take), 0);
    rst = 1'b0;
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // all ones on the first staged pixel after reset must not appear early
    px_red = 8'hFF; px_grn = 8'hFF; px_blu = 8'hFF; px_hs = 1; px_vs = 1; px_de = 1;
    for (int m = 0; m < 4; m++) begin
      run_phase(m, 1'b0, 30, 1'b0);
      run_phase(m, 1'b1, 30, 1'b0);
    end
    run_phase(0, 1'b0, 200, 1'b1);
    do_reset();
    run_phase(2, 1'b1, 20, 1'b0);
    run_phase(1, 1'b0, 20, 1'b0);
    repeat (14) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule